// File: doc/BRIEF.md
# Token-Ring Sequenced Dual-Port Memory Bank

This block is a small two-port storage bank, one write port and one read port, that has no address inputs at all. Each port owns a ring of row cells in which exactly one cell holds a token. The token marks the row that port will touch on its next enabled access. An enabled access acts on the tokened row, and the token then moves one cell along the ring. After the highest row it returns to row 0, so each port walks the rows in a fixed circular order.

The read and write rings are independent. Each has its own synchronous reset, which sends only that ring's token home to row 0, and its own enable. Read data is registered and appears after the clock edge that performed the read. If both ports hit the same row in one cycle, the read returns the value held before that write. This makes the bank a natural fit for circular buffers, delay lines and sequential write/read interleaving, where the access order is known in advance.

Top module: `seqmem_bank`

## Requirements
- R1: A high `wr_rst` at a clock edge puts the write token on row 0. It does not move the read token and does not change `rd_data`.
- R2: A high `rd_rst` at a clock edge puts the read token on row 0 and clears `rd_data` to zero. It does not move the write token.
- R3: After its first reset, each ring holds exactly one token. At most one write row select and at most one read row select are active in any cycle.
- R4: With `rd_en` low and `rd_rst` low, `rd_data` and the read token keep their values across the edge.
- R5: An edge with `rd_en` high and `rd_rst` low loads `rd_data` with the word in the read-tokened row, visible after that edge. The read token then moves to the next higher row.
- R6: An edge with `wr_en` high and `wr_rst` low stores `wr_data` in the write-tokened row and moves the write token to the next higher row. With `wr_en` low, no row is written and the token stays put.
- R7: From the last row (ROWS-1), the next access on either port goes to row 0.
- R8: When a read and a write act on the same row at one edge, `rd_data` receives the word held before that write. The new word is returned by a later read of that row.
- R9: A port's reset wins over its enable in the same cycle. With `wr_rst` high, `wr_en` writes nothing. With `rd_rst` high, `rd_en` reads nothing and does not advance the read token.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| wr_rst | input | 1 | Synchronous reset of the write ring, active high |
| wr_en | input | 1 | Write the tokened row and advance the write token |
| wr_data | input | WIDTH | Word to store |
| rd_rst | input | 1 | Synchronous reset of the read ring and read register, active high |
| rd_en | input | 1 | Read the tokened row and advance the read token |
| rd_data | output | WIDTH | Registered read word |

## Verification
A ring that loses its token, grows a second one, or steps the wrong way has no direct output. It shows up as a wrong word on `rd_data` one edge after the first read that uses the corrupted position. For the write ring, it shows up at the later read of the row that should have been written. The bench therefore writes a distinct word to every row and reads the rows back in order. It then resets the rings independently at different offsets, so that a shared or crossed reset changes which row later reads return. Same-row collisions and reset-with-enable cycles are placed where a wrong choice changes the very next `rd_data`.

// File: rtl/seqmem_pkg.sv
package seqmem_pkg;
   parameter int unsigned SEQ_ROWS_DEF  = 16;
   parameter int unsigned SEQ_WIDTH_DEF = 16;

   // Which side a ring serves; selects the reset-versus-enable gating variant
   typedef enum logic {RING_WR = 1'b0, RING_RD = 1'b1} ring_kind_e;
endpackage

// File: rtl/seqmem_ring.sv
module seqmem_ring
   import seqmem_pkg::*;
#(
   parameter int unsigned ROWS = SEQ_ROWS_DEF,
   parameter ring_kind_e  KIND = RING_RD
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            adv,
   output logic [ROWS-1:0] tok,
   output logic [ROWS-1:0] wl
);
   localparam int unsigned LAST = ROWS - 1;

   logic step;
   assign step = adv & ~rst;

   // One cell per row; each cell only looks at its lower neighbour
   for (genvar k = 0; k < ROWS; k++) begin : g_cell
      localparam int unsigned PREV = (k == 0) ? LAST : k - 1;
      localparam logic        HOME = (k == 0) ? 1'b1 : 1'b0;
      always_ff @(posedge clk) begin
         if (rst)       tok[k] <= HOME;
         else if (step) tok[k] <= tok[PREV];
      end
   end

   // Row select: the write side gates with reset directly; the read side
   // also gates it, but through the same step term for a single fan-out
   if (KIND == RING_WR) begin : g_wsel
      assign wl = (adv && !rst) ? tok : '0;
   end else begin : g_rsel
      assign wl = step ? tok : '0;
   end
endmodule

// File: rtl/seqmem_array.sv
module seqmem_array
   import seqmem_pkg::*;
#(
   parameter int unsigned ROWS  = SEQ_ROWS_DEF,
   parameter int unsigned WIDTH = SEQ_WIDTH_DEF
) (
   input  logic             clk,
   input  logic [ROWS-1:0]  wr_wl,
   input  logic [WIDTH-1:0] wr_data,
   input  logic [ROWS-1:0]  rd_wl,
   input  logic             rd_rst,
   output logic [WIDTH-1:0] rd_data
);
   logic [WIDTH-1:0] cells [ROWS];
   logic [WIDTH-1:0] rd_mux;

   always_ff @(posedge clk) begin
      for (int k = 0; k < ROWS; k++) begin
         if (wr_wl[k]) cells[k] <= wr_data;
      end
   end

   // AND-OR selection from a one-hot select, no decoder
   always_comb begin
      rd_mux = '0;
      for (int k = 0; k < ROWS; k++) begin
         if (rd_wl[k]) rd_mux = rd_mux | cells[k];
      end
   end

   // Non-blocking update sees the pre-write word on a same-row collision
   always_ff @(posedge clk) begin
      if (rd_rst)      rd_data <= '0;
      else if (|rd_wl) rd_data <= rd_mux;
   end
endmodule

// File: rtl/seqmem_bank.sv
module seqmem_bank
   import seqmem_pkg::*;
#(
   parameter int unsigned ROWS  = SEQ_ROWS_DEF,
   parameter int unsigned WIDTH = SEQ_WIDTH_DEF
) (
   input  logic             clk,
   input  logic             wr_rst,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] wr_data,
   input  logic             rd_rst,
   input  logic             rd_en,
   output logic [WIDTH-1:0] rd_data
);
   if (ROWS < 2) begin : g_bad_rows
      $error("seqmem_bank: ROWS must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("seqmem_bank: WIDTH must be at least 1");
   end

   logic [ROWS-1:0] wr_tok, wr_wl;
   logic [ROWS-1:0] rd_tok, rd_wl;

   seqmem_ring #(.ROWS(ROWS), .KIND(RING_WR)) u_wr_ring (
      .clk (clk),
      .rst (wr_rst),
      .adv (wr_en),
      .tok (wr_tok),
      .wl  (wr_wl)
   );

   seqmem_ring #(.ROWS(ROWS), .KIND(RING_RD)) u_rd_ring (
      .clk (clk),
      .rst (rd_rst),
      .adv (rd_en),
      .tok (rd_tok),
      .wl  (rd_wl)
   );

   seqmem_array #(.ROWS(ROWS), .WIDTH(WIDTH)) u_array (
      .clk     (clk),
      .wr_wl   (wr_wl),
      .wr_data (wr_data),
      .rd_wl   (rd_wl),
      .rd_rst  (rd_rst),
      .rd_data (rd_data)
   );
endmodule

// File: rtl/seqmem_bank_chk.sv
module seqmem_bank_chk #(
   parameter int unsigned ROWS  = 16,
   parameter int unsigned WIDTH = 16
) (
   input logic             clk,
   input logic             wr_rst,
   input logic             wr_en,
   input logic             rd_rst,
   input logic             rd_en,
   input logic [WIDTH-1:0] rd_data,
   input logic [ROWS-1:0]  wr_tok,
   input logic [ROWS-1:0]  rd_tok,
   input logic [ROWS-1:0]  wr_wl,
   input logic [ROWS-1:0]  rd_wl
);
   logic wr_live = 1'b0;
   logic rd_live = 1'b0;

   always_ff @(posedge clk) begin
      wr_live <= wr_live | wr_rst;
      rd_live <= rd_live | rd_rst;
   end

   // R3
   wr_tok_onehot_chk: assert property (@(posedge clk) disable iff (!wr_live)
      $onehot(wr_tok));
   // R3
   rd_tok_onehot_chk: assert property (@(posedge clk) disable iff (!rd_live)
      $onehot(rd_tok));
   // R3
   row_select_single_chk: assert property (@(posedge clk) disable iff (!(wr_live && rd_live))
      $onehot0(wr_wl) && $onehot0(rd_wl));
   // R2
   rd_home_chk: assert property (@(posedge clk) disable iff (!rd_live)
      rd_rst |=> (rd_tok[0] && $onehot(rd_tok) && rd_data == '0));
   // R1
   wr_home_chk: assert property (@(posedge clk) disable iff (!(wr_live && rd_live))
      (wr_rst && !rd_rst && !rd_en) |=> (wr_tok[0] && $stable(rd_tok) && $stable(rd_data)));
   // R4
   rd_idle_hold_chk: assert property (@(posedge clk) disable iff (!rd_live)
      (!rd_en && !rd_rst) |=> ($stable(rd_data) && $stable(rd_tok)));
   // R5
   rd_step_chk: assert property (@(posedge clk) disable iff (!rd_live)
      (rd_en && !rd_rst) |=> rd_tok == {$past(rd_tok[ROWS-2:0]), $past(rd_tok[ROWS-1])});
   // R6
   wr_step_chk: assert property (@(posedge clk) disable iff (!wr_live)
      (wr_en && !wr_rst) |=> wr_tok == {$past(wr_tok[ROWS-2:0]), $past(wr_tok[ROWS-1])});
   // R6
   wr_idle_hold_chk: assert property (@(posedge clk) disable iff (!wr_live)
      (!wr_en && !wr_rst) |=> $stable(wr_tok));
   // R9
   rd_rst_wins_chk: assert property (@(posedge clk) disable iff (!rd_live)
      rd_rst |-> rd_wl == '0);
   // R9
   wr_rst_wins_chk: assert property (@(posedge clk) disable iff (!wr_live)
      wr_rst |-> wr_wl == '0);
endmodule

bind seqmem_bank seqmem_bank_chk #(.ROWS(ROWS), .WIDTH(WIDTH)) u_chk (
   .clk     (clk),
   .wr_rst  (wr_rst),
   .wr_en   (wr_en),
   .rd_rst  (rd_rst),
   .rd_en   (rd_en),
   .rd_data (rd_data),
   .wr_tok  (wr_tok),
   .rd_tok  (rd_tok),
   .wr_wl   (wr_wl),
   .rd_wl   (rd_wl)
);

// File: tb/seqmem_bank_bench.sv
module seqmem_bank_bench;
   localparam int ROWS  = 16;
   localparam int WIDTH = 16;

   logic             clk = 1'b0;
   logic             wr_rst = 1'b0, wr_en = 1'b0, rd_rst = 1'b0, rd_en = 1'b0;
   logic [WIDTH-1:0] wr_data = '0;
   logic [WIDTH-1:0] rd_data;

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   logic [WIDTH-1:0] ref_mem [ROWS];
   int               wp = 0, rp = 0;
   logic [WIDTH-1:0] exp_rd = '0;

   always #10 clk = ~clk;   // 50 MHz

   seqmem_bank #(.ROWS(ROWS), .WIDTH(WIDTH)) u_seqmem_bank (
      .clk     (clk),
      .wr_rst  (wr_rst),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .rd_rst  (rd_rst),
      .rd_en   (rd_en),
      .rd_data (rd_data)
   );

   task automatic check(input string tag, input logic [WIDTH-1:0] act, input logic [WIDTH-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: rd_data=%h expected %h", tag, act, exp);
      end
   endtask

   // One clock: drive at the falling edge, let the rising edge act, sample at the next fall
   task automatic step(input logic we, input logic [WIDTH-1:0] wd, input logic re,
                       input logic wrst, input logic rrst, input string tag);
      logic [WIDTH-1:0] old;
      wr_en = we; wr_data = wd; rd_en = re; wr_rst = wrst; rd_rst = rrst;
      old = ref_mem[rp];
      if (rrst) begin rp = 0; exp_rd = '0; end
      else if (re) begin exp_rd = old; rp = (rp + 1) % ROWS; end
      if (wrst) wp = 0;
      else if (we) begin ref_mem[wp] = wd; wp = (wp + 1) % ROWS; end
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0; wr_rst = 1'b0; rd_rst = 1'b0;
      check(tag, rd_data, exp_rd);
   endtask

   task automatic t_reset;
      step(1'b0, '0, 1'b0, 1'b1, 1'b1, "R2 reset clears rd_data");
   endtask

   task automatic t_fill_and_read;
      for (int i = 0; i < ROWS; i++) step(1'b1, 16'hA000 + 16'(i), 1'b0, 1'b0, 1'b0, "R4 no read while writing");
      for (int i = 0; i < ROWS; i++) step(1'b0, '0, 1'b1, 1'b0, 1'b0, "R5 R6 sequential read-back");
   endtask

   task automatic t_wrap;
      for (int i = 0; i < 3; i++) step(1'b1, 16'hB100 + 16'(i), 1'b0, 1'b0, 1'b0, "R7 wrapped write");
      for (int i = 0; i < 3; i++) step(1'b0, '0, 1'b1, 1'b0, 1'b0, "R7 wrapped read");
   endtask

   task automatic t_hold;
      for (int i = 0; i < 3; i++) step(1'b0, 16'hDEAD, 1'b0, 1'b0, 1'b0, "R4 rd_data holds");
      step(1'b0, '0, 1'b1, 1'b0, 1'b0, "R6 idle wr_en stored nothing");
   endtask

   task automatic t_indep_reset;
      step(1'b1, 16'hC001, 1'b0, 1'b0, 1'b0, "R6 write row");
      step(1'b1, 16'hC002, 1'b0, 1'b0, 1'b0, "R6 write row");
      step(1'b0, '0, 1'b0, 1'b0, 1'b1, "R2 read ring home");
      step(1'b1, 16'hC003, 1'b0, 1'b0, 1'b0, "R2 write ring kept place");
      for (int i = 0; i < 7; i++) step(1'b0, '0, 1'b1, 1'b0, 1'b0, "R2 read from row 0");
      step(1'b0, '0, 1'b0, 1'b1, 1'b0, "R1 write ring home, rd_data kept");
      step(1'b1, 16'hC0FF, 1'b0, 1'b0, 1'b0, "R1 write to row 0");
      for (int i = 0; i < ROWS - 7 + 1; i++) step(1'b0, '0, 1'b1, 1'b0, 1'b0, "R1 read ring kept place");
   endtask

   task automatic t_same_row;
      step(1'b0, '0, 1'b0, 1'b1, 1'b1, "R2 both home");
      step(1'b1, 16'hE0E0, 1'b1, 1'b0, 1'b0, "R8 collision returns old word");
      step(1'b1, 16'hE1E1, 1'b1, 1'b0, 1'b0, "R8 collision returns old word");
      step(1'b0, '0, 1'b0, 1'b0, 1'b1, "R2 read home");
      step(1'b0, '0, 1'b1, 1'b0, 1'b0, "R8 new word visible later");
      step(1'b0, '0, 1'b1, 1'b0, 1'b0, "R8 new word visible later");
   endtask

   task automatic t_rst_priority;
      step(1'b1, 16'h5A5A, 1'b1, 1'b1, 1'b1, "R9 reset beats enable");
      step(1'b0, '0, 1'b1, 1'b0, 1'b0, "R9 row 0 not overwritten, read not advanced");
      step(1'b1, 16'h6B6B, 1'b0, 1'b0, 1'b0, "R9 write lands on row 0");
      step(1'b0, '0, 1'b0, 1'b0, 1'b1, "R2 read home");
      step(1'b0, '0, 1'b1, 1'b0, 1'b0, "R9 row 0 holds new word");
   endtask

   initial begin
      @(negedge clk);
      t_reset();
      t_fill_and_read();
      t_wrap();
      t_hold();
      t_indep_reset();
      t_same_row();
      t_rst_priority();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: run did not complete, actual hung expected finished");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule